// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Decoder

This block is a slave on a two-wire serial bus that controls a digital potentiometer. It runs on a fast system clock and samples the bus clock and data lines through two-flop synchronizers. From the synchronized samples it finds bus start and stop conditions, frames the bytes and acknowledges them. It drives the data line only by pulling it low, through an output enable. The address byte has no direction bit. The opcode in the second byte sets the direction, and it also sets whether the command ends after that byte or carries a third one.

The decoder does not hold the wiper or the data registers. It tells the surrounding logic what to do. It outputs a register select, a write value and four one-cycle action strobes. It accepts the current wiper value and the selected data register for reads. In step mode it outputs up and down pulses. The register bank reports a nonvolatile write in progress on a busy input. While that input is high the address is refused, so a host can poll until the write completes.

Top module: `twowire_pot_decoder`

## Requirements
- R1: After reset, `sda_oe`, `step_en`, `step_up`, `step_dn` and all four action strobes are 0.
- R2: A start condition is the data line falling while the clock line is high. A stop condition is the data line rising while the clock line is high. Before the first start, the block acknowledges no byte.
- R3: Bytes are sent MSB first. The address byte is acknowledged (`sda_oe` high during the ninth clock) only when it equals 0,1,0,1,`strap[2]`,`strap[1]`,0,`strap[0]`. After a mismatch, nothing is acknowledged until the next start condition.
- R4: While `nv_busy` is high when the address decision is made, the address is not acknowledged.
- R5: In the instruction byte, bits 7:4 are the opcode and bits 3:2 are the register select. The known opcodes are 1001, 1010, 1011, 1100, 1101, 1110 and 0010. Any other opcode is not acknowledged.
- R6: Opcode 1010 (load wiper) and opcode 1100 (store to data register) take a third byte and acknowledge it. Its low six bits appear on `wr_value`. The stop condition that follows gives exactly one cycle of `wr_wiper` or `wr_dreg`.
- R7: Opcode 1001 (read wiper) and opcode 1011 (read data register) make the slave send 0,0 followed by the six-bit value, MSB first. The slave releases the line for the master's acknowledge and pulses no strobe.
- R8: Opcode 1101 (data register to wiper) and opcode 1110 (wiper to data register) end after the instruction acknowledge. The stop condition that follows gives one cycle of `xfer_to_wiper` or `xfer_to_dreg`, together with the latched `reg_sel`.
- R9: After opcode 0010 is acknowledged, `step_en` is high until the next start or stop condition. Each rising clock edge in that mode gives one pulse: `step_up` if the data line is high, `step_dn` if it is low. The rising edge that sets up the stop condition also counts.
- R10: A start condition in the middle of a command abandons that command, and no strobe is issued for it.
- R11: `sda_oe` changes only in the system cycle after a falling bus clock is detected, so it is stable while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| strap | input | 3 | Address straps: [2] and [1] form address bits 3 and 2, [0] forms address bit 0 |
| nv_busy | input | 1 | Nonvolatile write in progress |
| wiper_q | input | VW | Current wiper value |
| dreg_q | input | VW | Data register chosen by `reg_sel` |
| sda_oe | output | 1 | Pull the data line low |
| reg_sel | output | 2 | Register select latched from the instruction byte |
| wr_value | output | VW | Value received in the third byte |
| wr_wiper | output | 1 | Load `wr_value` into the wiper |
| wr_dreg | output | 1 | Store `wr_value` into the selected data register |
| xfer_to_wiper | output | 1 | Copy the selected data register into the wiper |
| xfer_to_dreg | output | 1 | Copy the wiper into the selected data register |
| step_en | output | 1 | Step mode active |
| step_up | output | 1 | Move the wiper up one step |
| step_dn | output | 1 | Move the wiper down one step |

## Verification
The busy input can change in the same system cycle in which the address acknowledge is decided. The bench raises and lowers `nv_busy` around address bytes, including at that exact decision cycle. A behavioural model then judges every clock using the busy value present at that edge. Two other events land together by design: the last step pulse and the set-up of the stop condition. A step sequence is closed with a stop, and the bench expects the extra down step in the final wiper value.

// File: rtl/twowire_pot_decoder.sv
module twowire_pot_decoder #(
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [2:0]    strap,
  input  logic          nv_busy,
  input  logic [VW-1:0] wiper_q,
  input  logic [VW-1:0] dreg_q,
  output logic          sda_oe,
  output logic [1:0]    reg_sel,
  output logic [VW-1:0] wr_value,
  output logic          wr_wiper,
  output logic          wr_dreg,
  output logic          xfer_to_wiper,
  output logic          xfer_to_dreg,
  output logic          step_en,
  output logic          step_up,
  output logic          step_dn
);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_INSTR, P_WDATA, P_RDATA, P_DONE, P_STEP} phase_t;

  localparam logic [3:0] TYPE_ID = 4'b0101;
  localparam logic [3:0] OP_RDW  = 4'b1001;
  localparam logic [3:0] OP_WRW  = 4'b1010;
  localparam logic [3:0] OP_RDD  = 4'b1011;
  localparam logic [3:0] OP_WRD  = 4'b1100;
  localparam logic [3:0] OP_D2W  = 4'b1101;
  localparam logic [3:0] OP_W2D  = 4'b1110;
  localparam logic [3:0] OP_STEP = 4'b0010;

  logic [2:0] scl_p, sda_p;
  phase_t     phase;
  logic [3:0] cnt;
  logic [7:0] sh, tx, rd_byte;
  logic [3:0] op;
  logic       pend, op_known, ack_ok;

  wire scl_r   =  scl_p[1] & ~scl_p[2];
  wire scl_f   = ~scl_p[1] &  scl_p[2];
  wire start_c =  scl_p[1] &  scl_p[2] &  sda_p[2] & ~sda_p[1];
  wire stop_c  =  scl_p[1] &  scl_p[2] & ~sda_p[2] &  sda_p[1];
  wire addr_ok = sh == {TYPE_ID, strap[2], strap[1], 1'b0, strap[0]};

  assign step_en = (phase == P_STEP);
  assign rd_byte = (op == OP_RDW) ? 8'(wiper_q) : 8'(dreg_q);

  always_comb begin
    case (sh[7:4])
      OP_RDW, OP_WRW, OP_RDD, OP_WRD, OP_D2W, OP_W2D, OP_STEP: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
    case (phase)
      P_ADDR:  ack_ok = addr_ok & ~nv_busy;
      P_INSTR: ack_ok = op_known;
      P_WDATA: ack_ok = 1'b1;
      default: ack_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;  cnt <= '0;  sh <= '0;  tx <= '0;  op <= '0;  pend <= 1'b0;
      sda_oe <= 1'b0;  reg_sel <= '0;  wr_value <= '0;
      wr_wiper <= 1'b0;  wr_dreg <= 1'b0;  xfer_to_wiper <= 1'b0;  xfer_to_dreg <= 1'b0;
      step_up <= 1'b0;  step_dn <= 1'b0;
    end else begin
      wr_wiper <= 1'b0;  wr_dreg <= 1'b0;  xfer_to_wiper <= 1'b0;  xfer_to_dreg <= 1'b0;
      step_up <= 1'b0;  step_dn <= 1'b0;
      if (start_c) begin
        phase <= P_ADDR;  cnt <= '0;  pend <= 1'b0;  sda_oe <= 1'b0;
      end else if (stop_c) begin
        phase <= P_IDLE;  cnt <= '0;  pend <= 1'b0;  sda_oe <= 1'b0;
        if (pend) begin
          wr_wiper      <= (op == OP_WRW);
          wr_dreg       <= (op == OP_WRD);
          xfer_to_wiper <= (op == OP_D2W);
          xfer_to_dreg  <= (op == OP_W2D);
        end
      end else begin
        case (phase)
          P_ADDR, P_INSTR, P_WDATA: begin
            if (scl_r && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_p[1]};
              cnt <= cnt + 4'd1;
            end else if (scl_f && cnt == 4'd8) begin
              cnt    <= 4'd9;
              sda_oe <= ack_ok;
              if (!ack_ok) phase <= P_IDLE;
              if (phase == P_INSTR) begin
                op      <= sh[7:4];
                reg_sel <= sh[3:2];
              end
              if (phase == P_WDATA) wr_value <= sh[VW-1:0];
            end else if (scl_f && cnt == 4'd9) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              if (phase == P_ADDR) phase <= P_INSTR;
              else if (phase == P_WDATA) begin
                phase <= P_DONE;
                pend  <= 1'b1;
              end else begin
                case (op)
                  OP_RDW, OP_RDD: begin
                    phase  <= P_RDATA;
                    tx     <= rd_byte;
                    sda_oe <= ~rd_byte[7];
                  end
                  OP_WRW, OP_WRD: phase <= P_WDATA;
                  OP_D2W, OP_W2D: begin
                    phase <= P_DONE;
                    pend  <= 1'b1;
                  end
                  OP_STEP: phase <= P_STEP;
                  default: phase <= P_IDLE;
                endcase
              end
            end
          end
          P_RDATA: begin
            if (scl_r && cnt < 4'd8) cnt <= cnt + 4'd1;
            else if (scl_f && cnt != 4'd0 && cnt < 4'd8) begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end else if (scl_f && cnt == 4'd8) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd9;
            end else if (scl_f && cnt == 4'd9) begin
              phase <= P_DONE;
              cnt   <= '0;
            end
          end
          P_STEP: begin
            if (scl_r) begin
              step_up <= sda_p[1];
              step_dn <= ~sda_p[1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_p[1])); // R11
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_ADDR && scl_f && cnt == 4'd8 && nv_busy) |=> !sda_oe); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_wiper, wr_dreg, xfer_to_wiper, xfer_to_dreg})); // R6
  AST_STROBE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wiper || wr_dreg || xfer_to_wiper || xfer_to_dreg) |-> $past(stop_c)); // R8
  AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R9
  AST_STEP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> ($past(scl_r) && step_en)); // R9

endmodule

// File: tb/test_twowire_pot_decoder.sv
module test_twowire_pot_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, nv_busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [5:0] wip, wr_value, dreg_q;
  logic [5:0] dr [4];
  logic sda_oe, wr_wiper, wr_dreg, xfer_to_wiper, xfer_to_dreg, step_en, step_up, step_dn;
  logic [1:0] reg_sel;
  wire scl_line = m_scl;
  wire sda_line = m_sda & ~sda_oe;
  int n_chk = 0, n_bad = 0, oe_viol = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twowire_pot_decoder #(.VW(6)) i_twowire_pot_decoder (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line), .strap(strap),
    .nv_busy(nv_busy), .wiper_q(wip), .dreg_q(dreg_q), .sda_oe(sda_oe), .reg_sel(reg_sel),
    .wr_value(wr_value), .wr_wiper(wr_wiper), .wr_dreg(wr_dreg), .xfer_to_wiper(xfer_to_wiper),
    .xfer_to_dreg(xfer_to_dreg), .step_en(step_en), .step_up(step_up), .step_dn(step_dn));

  assign dreg_q = dr[reg_sel];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 6'd0;  dr[0] <= 6'd5;  dr[1] <= 6'd10;  dr[2] <= 6'd20;  dr[3] <= 6'd40;
    end else begin
      if (wr_wiper) wip <= wr_value;
      if (wr_dreg) dr[reg_sel] <= wr_value;
      if (xfer_to_wiper) wip <= dr[reg_sel];
      if (xfer_to_dreg) dr[reg_sel] <= wip;
      if (step_up && wip != 6'd63) wip <= wip + 6'd1;
      if (step_dn && wip != 6'd0) wip <= wip - 6'd1;
    end
  end

  // behavioural reference model, evaluated at every rising clock
  bit hs[$], hd[$];
  int m_ph, m_cnt, m_byte, m_op, m_tx;
  bit m_pend;
  int e_oe, e_sel, e_val, e_strb, e_up, e_dn;

  always @(posedge clk) begin
    if (!rst_n) begin
      hs = '{1, 1, 1, 1};  hd = '{1, 1, 1, 1};
      m_ph = 0;  m_cnt = 0;  m_byte = 0;  m_op = 0;  m_tx = 0;  m_pend = 0;
      e_oe = 0;  e_sel = 0;  e_val = 0;  e_strb = 0;  e_up = 0;  e_dn = 0;
    end else begin
      bit ns, os, nd, od, ok;
      hs.push_front(scl_line);  hd.push_front(sda_line);
      void'(hs.pop_back());  void'(hd.pop_back());
      ns = hs[2];  os = hs[3];  nd = hd[2];  od = hd[3];
      e_strb = 0;  e_up = 0;  e_dn = 0;
      if (ns && os && od && !nd) begin
        m_ph = 1;  m_cnt = 0;  m_pend = 0;  e_oe = 0;
      end else if (ns && os && !od && nd) begin
        if (m_pend) e_strb = (m_op == 10) ? 8 : (m_op == 12) ? 4 : (m_op == 13) ? 2 : (m_op == 14) ? 1 : 0;
        m_ph = 0;  m_cnt = 0;  m_pend = 0;  e_oe = 0;
      end else if (ns && !os) begin
        if (m_ph >= 1 && m_ph <= 3 && m_cnt < 8) begin
          m_byte = (m_byte * 2 + nd) % 256;  m_cnt++;
        end else if (m_ph == 4 && m_cnt < 8) m_cnt++;
        else if (m_ph == 6) begin e_up = nd;  e_dn = !nd; end
      end else if (!ns && os) begin
        if (m_ph >= 1 && m_ph <= 3) begin
          if (m_cnt == 8) begin
            if (m_ph == 1) ok = (m_byte == (80 + strap[2]*8 + strap[1]*4 + strap[0])) && !nv_busy;
            else if (m_ph == 2) ok = (m_byte / 16) inside {9, 10, 11, 12, 13, 14, 2};
            else ok = 1;
            e_oe = ok;  m_cnt = 9;
            if (m_ph == 2) begin m_op = m_byte / 16;  e_sel = (m_byte / 4) % 4; end
            if (m_ph == 3) e_val = m_byte % 64;
            if (!ok) m_ph = 0;
          end else if (m_cnt == 9) begin
            m_cnt = 0;  e_oe = 0;
            if (m_ph == 1) m_ph = 2;
            else if (m_ph == 3) begin m_ph = 5;  m_pend = 1; end
            else if (m_op == 9 || m_op == 11) begin
              m_ph = 4;  m_tx = (m_op == 9) ? int'(wip) : int'(dreg_q);  e_oe = 1;
            end else if (m_op == 10 || m_op == 12) m_ph = 3;
            else if (m_op == 13 || m_op == 14) begin m_ph = 5;  m_pend = 1; end
            else m_ph = 6;
          end
        end else if (m_ph == 4) begin
          if (m_cnt >= 1 && m_cnt <= 7) e_oe = ((m_tx >> (7 - m_cnt)) % 2 == 0);
          else if (m_cnt == 8) begin e_oe = 0;  m_cnt = 9; end
          else if (m_cnt == 9) begin m_ph = 5;  m_cnt = 0; end
        end
      end
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk += 3;
      if (int'(sda_oe) != e_oe) begin
        n_bad++;  $display("FAIL R3 cycle sda_oe got=%0d exp=%0d t=%0t", sda_oe, e_oe, $time);
      end
      if ({wr_wiper, wr_dreg, xfer_to_wiper, xfer_to_dreg} != 4'(e_strb) || int'(reg_sel) != e_sel || int'(wr_value) != e_val) begin
        n_bad++;
        $display("FAIL R6 cycle strobes/sel/val got=%b/%0d/%0d exp=%b/%0d/%0d t=%0t",
                 {wr_wiper, wr_dreg, xfer_to_wiper, xfer_to_dreg}, reg_sel, wr_value, 4'(e_strb), e_sel, e_val, $time);
      end
      if (int'(step_up) != e_up || int'(step_dn) != e_dn || int'(step_en) != int'(m_ph == 6)) begin
        n_bad++;
        $display("FAIL R9 cycle step en/up/dn got=%0d%0d%0d exp=%0d%0d%0d t=%0t",
                 step_en, step_up, step_dn, m_ph == 6, e_up, e_dn, $time);
      end
      if (sda_oe != prev_oe && scl_line) oe_viol++;
    end
    prev_oe = sda_oe;
  end

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;  $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1;  wait_clk(HALF);  m_scl = 1'b1;  wait_clk(2*HALF);
    m_sda = 1'b0;  wait_clk(2*HALF);  m_scl = 1'b0;  wait_clk(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;  wait_clk(HALF);  m_scl = 1'b1;  wait_clk(2*HALF);
    m_sda = 1'b1;  wait_clk(2*HALF);
  endtask

  task automatic send_bit(bit b);
    m_sda = b;  wait_clk(HALF);  m_scl = 1'b1;  wait_clk(2*HALF);  m_scl = 1'b0;  wait_clk(HALF);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1;  wait_clk(HALF);  m_scl = 1'b1;  wait_clk(HALF);
    acked = ~sda_line;  wait_clk(HALF);  m_scl = 1'b0;  wait_clk(HALF);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1;  wait_clk(HALF);  m_scl = 1'b1;  wait_clk(HALF);
      b[i] = sda_line;  wait_clk(HALF);  m_scl = 1'b0;  wait_clk(HALF);
    end
    send_bit(1'b1);
  endtask

  localparam logic [7:0] ADDR = 8'h59;

  initial begin
    bit a;
    logic [7:0] rb;
    wait_clk(4);
    check("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;  wait_clk(3);
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 step_en after reset", step_en, 0);
    check("R1 strobes after reset", {wr_wiper, wr_dreg, xfer_to_wiper, xfer_to_dreg, step_up, step_dn}, 0);

    send_byte(ADDR, a);  check("R2 no ack before any start", a, 0);
    bus_stop();

    bus_start();  send_byte(ADDR, a);  check("R3 address ack", a, 1);
    send_byte(8'hA0, a);  check("R5 load-wiper opcode ack", a, 1);
    send_byte(8'h2A, a);  check("R6 data byte ack", a, 1);
    bus_stop();  wait_clk(4);  check("R6 wiper loaded", wip, 42);

    bus_start();  send_byte(ADDR, a);  send_byte(8'h90, a);  check("R5 read-wiper ack", a, 1);
    recv_byte(rb);  bus_stop();  check("R7 read wiper byte", rb, 42);
    check("R7 no strobe on read, wiper kept", wip, 42);

    bus_start();  send_byte(ADDR, a);  send_byte(8'hC8, a);  send_byte(8'h15, a);
    check("R6 data register byte ack", a, 1);  bus_stop();  wait_clk(4);
    check("R6 data register 2 stored", dr[2], 21);
    bus_start();  send_byte(ADDR, a);  send_byte(8'hB8, a);  recv_byte(rb);  bus_stop();
    check("R7 read data register 2", rb, 21);

    bus_start();  send_byte(ADDR, a);  send_byte(8'hD4, a);  check("R8 copy opcode ack", a, 1);
    bus_stop();  wait_clk(4);  check("R8 data register 1 copied to wiper", wip, 10);
    bus_start();  send_byte(ADDR, a);  send_byte(8'hEC, a);  bus_stop();  wait_clk(4);
    check("R8 wiper copied to data register 3", dr[3], 10);

    bus_start();  send_byte(8'h5B, a);  check("R3 fixed zero bit mismatch nack", a, 0);
    send_byte(8'hA0, a);  check("R3 idle after mismatch", a, 0);  bus_stop();
    bus_start();  send_byte(8'h49, a);  check("R3 type id mismatch nack", a, 0);  bus_stop();
    bus_start();  send_byte(8'h58, a);  check("R3 strap bit mismatch nack", a, 0);  bus_stop();

    nv_busy = 1'b1;
    bus_start();  send_byte(ADDR, a);  check("R4 busy refuses address", a, 0);  bus_stop();
    nv_busy = 1'b0;
    bus_start();  send_byte(ADDR, a);  check("R4 ack after busy clears", a, 1);
    send_byte(8'h30, a);  check("R5 unknown opcode nack", a, 0);  bus_stop();

    bus_start();  send_byte(ADDR, a);
    for (int i = 0; i < 7; i++) m_sda = ADDR[7-i];
    send_byte(8'h20, a);  check("R5 step opcode ack", a, 1);
    wait_clk(2);  check("R9 step mode entered", step_en, 1);
    send_bit(1'b1);  send_bit(1'b1);  send_bit(1'b1);  send_bit(1'b0);
    bus_stop();  wait_clk(4);
    check("R9 three up, two down", wip, 11);
    check("R9 step mode left on stop", step_en, 0);

    bus_start();  send_byte(ADDR, a);  send_byte(8'hA0, a);  send_byte(8'h3F, a);
    bus_start();  bus_stop();  wait_clk(4);
    check("R10 aborted load leaves wiper", wip, 11);
    bus_start();  send_byte(ADDR, a);  send_byte(8'hD0, a);
    bus_start();  send_byte(ADDR, a);  check("R10 address after repeated start", a, 1);
    bus_stop();  wait_clk(4);
    check("R10 aborted copy leaves wiper", wip, 11);

    nv_busy = 1'b1;  bus_start();  send_byte(ADDR, a);  nv_busy = 1'b0;  bus_stop();
    check("R4 busy at decision nack", a, 0);

    check("R11 sda_oe stable while clock high", oe_viol, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;  n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule